// File: doc/BRIEF.md
# Split-Operand Unsigned Multiplier with Precomputed Top-Quarter Increment

This block multiplies two unsigned `W`-bit operands and returns the full `2W`-bit product. Each operand is cut into a low and a high half. Four half-width multipliers run side by side and form the four cross products.

The lowest quarter of the result is read directly from the low-by-low product. The middle half is formed in two steps. A carry-save row first folds together the two cross products and a row built from the high-by-high low half and the low-by-low high half. A block carry-select adder then resolves that row.

The top quarter is never sent through a wide final adder. The high half of the high-by-high product is prepared in three forms at once: unchanged, plus one and plus two. The overflow count out of the middle stage picks one of them. That count is the adder's carry-out plus the most significant bit of the carry row, which the left shift pushes out. It can reach two, for example when both operands are `0xF1FF`, so a plus-two candidate is kept next to the plus-one form.

An optional output register gives one cycle of latency; without it the block is purely combinational.

Top module: `splitmul_top`

## Requirements
- R1: With `OUT_REG=1`, `prod_o` equals `a_in*b_in` (unsigned, `2W` bits) one clock after the operands are presented; with `OUT_REG=0` it equals the product in the same cycle.
- R2: Product bits `[W/2-1:0]` equal the low `W/2` bits of `a_in[W/2-1:0]*b_in[W/2-1:0]`.
- R3: Product bits `[2W-1:W+W/2]` equal the high half of `a_in[W-1:W/2]*b_in[W-1:W/2]` plus the overflow count of the middle stage (0, 1 or 2).
- R4: The middle adder is built from `BLK`-bit blocks, each with precomputed carry-in-0 and carry-in-1 sums. For any inputs, its sum and carry-out equal the exact sum of its operands and carry-in.
- R5: The carry-save stage yields a sum row `s` and a carry row `c` with `s + 2*c` equal to the total of its three input rows.
- R6: The overflow count is the adder carry-out plus carry-row bit `W-1`. Together with the middle sum it equals the exact total of the three middle rows. With `a_in=b_in=0xF1FF` (`W=16`) the count is 2.
- R7: With `OUT_REG=1`, `rst_n` low (active low, asynchronous) forces `prod_o` to zero.
- R8: A zero operand yields zero. All-ones operands yield `0xFFFE0001` for `W=16`. Single-bit operands yield the matching power of two.
- R9: Each half-width base multiplier gives the exact `W`-bit product of its two `W/2`-bit inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_in | input | W | Multiplicand, unsigned |
| b_in | input | W | Multiplier, unsigned |
| prod_o | output | 2W | Unsigned product |

## Verification
The hardest situation to reach from the ports is an overflow count of two. This needs the adder carry-out and the shifted-out carry-row bit to be set together. It only happens when both cross products are large and the high-by-high low half is also large. Random operands seldom produce it.

The stimulus therefore adds a sweep. The low halves are held at all ones while the high halves sweep values whose squares leave large low bytes, `0xF1F1`-style patterns such as `0xF1FF`. For every vector, the bench computes the expected overflow from the partial products it forms itself and checks the top quarter against it.

// File: rtl/splitmul_pkg.sv
package splitmul_pkg;
    localparam int DEF_W   = 16;
    localparam int DEF_BLK = 4;

    function automatic int half_of(input int w);
        return w / 2;
    endfunction
endpackage

// File: rtl/splitmul_base.sv
module splitmul_base #(
    parameter int HW = 8
) (
    input  logic [HW-1:0]   a,
    input  logic [HW-1:0]   b,
    output logic [2*HW-1:0] p
);
    localparam int PW = 2 * HW;

    logic [PW-1:0] acc [0:HW];
    assign acc[0] = '0;

    for (genvar i = 0; i < HW; i++) begin : g_row
        logic [PW-1:0] pp;
        assign pp         = b[i] ? ({{HW{1'b0}}, a} << i) : '0;
        assign acc[i + 1] = acc[i] + pp;
    end

    assign p = acc[HW];

    always_comb begin
        if (!$isunknown({a, b}))
            a_r9_base_exact: assert (p == PW'(a) * PW'(b));
    end
endmodule

// File: rtl/splitmul_csa.sv
module splitmul_csa #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign s[i] = x[i] ^ y[i] ^ z[i];
        assign c[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end

    always_comb begin
        if (!$isunknown({x, y, z}))
            a_r5_csa_total: assert (({2'b00, s} + {1'b0, c, 1'b0}) ==
                                    ({2'b00, x} + {2'b00, y} + {2'b00, z}));
    end
endmodule

// File: rtl/splitmul_csla.sv
module splitmul_csla #(
    parameter int W   = 16,
    parameter int BLK = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NB = W / BLK;

    logic [NB:0] cy;
    assign cy[0] = cin;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        logic [BLK:0] s0;
        logic [BLK:0] s1;
        assign s0 = {1'b0, a[k*BLK +: BLK]} + {1'b0, b[k*BLK +: BLK]};
        assign s1 = {1'b0, a[k*BLK +: BLK]} + {1'b0, b[k*BLK +: BLK]} + (BLK+1)'(1);
        assign sum[k*BLK +: BLK] = cy[k] ? s1[BLK-1:0] : s0[BLK-1:0];
        assign cy[k + 1]         = cy[k] ? s1[BLK] : s0[BLK];
    end

    assign cout = cy[NB];

    always_comb begin
        if (!$isunknown({a, b, cin}))
            a_r4_csla_exact: assert ({cout, sum} ==
                                     ({1'b0, a} + {1'b0, b} + (W+1)'(cin)));
    end
endmodule

// File: rtl/splitmul_top.sv
module splitmul_top
    import splitmul_pkg::*;
#(
    parameter int W       = DEF_W,
    parameter int BLK     = DEF_BLK,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic [2*W-1:0] prod_o
);
    localparam int H = half_of(W);

    logic [H-1:0] xl, xh, yl, yh;
    assign xl = a_in[H-1:0];
    assign xh = a_in[W-1:H];
    assign yl = b_in[H-1:0];
    assign yh = b_in[W-1:H];

    logic [W-1:0] pp_ll, pp_hl, pp_lh, pp_hh;

    splitmul_base #(.HW(H)) u_ll (.a(xl), .b(yl), .p(pp_ll));
    splitmul_base #(.HW(H)) u_hl (.a(xh), .b(yl), .p(pp_hl));
    splitmul_base #(.HW(H)) u_lh (.a(xl), .b(yh), .p(pp_lh));
    splitmul_base #(.HW(H)) u_hh (.a(xh), .b(yh), .p(pp_hh));

    logic [W-1:0] joined_row;
    assign joined_row = {pp_hh[H-1:0], pp_ll[W-1:H]};

    logic [W-1:0] s_row, c_row;
    splitmul_csa #(.W(W)) u_csa (
        .x(pp_hl), .y(pp_lh), .z(joined_row), .s(s_row), .c(c_row)
    );

    logic [W-1:0] mid_sum;
    logic         mid_cout;
    splitmul_csla #(.W(W), .BLK(BLK)) u_csla (
        .a(s_row), .b({c_row[W-2:0], 1'b0}), .cin(1'b0),
        .sum(mid_sum), .cout(mid_cout)
    );

    logic [1:0] ovf;
    assign ovf = {1'b0, mid_cout} + {1'b0, c_row[W-1]};

    logic [H-1:0] top_plain, top_inc1, top_inc2, top_sel;
    assign top_plain = pp_hh[W-1:H];
    assign top_inc1  = top_plain + H'(1);
    assign top_inc2  = top_plain + H'(2);

    always_comb begin
        unique case (ovf)
            2'd0:    top_sel = top_plain;
            2'd1:    top_sel = top_inc1;
            default: top_sel = top_inc2;
        endcase
    end

    logic [2*W-1:0] z_comb;
    assign z_comb = {top_sel, mid_sum, pp_ll[H-1:0]};

    always_comb begin
        if (!$isunknown({a_in, b_in}))
            a_r6_overflow_count: assert ({ovf, mid_sum} ==
                ({2'b00, pp_hl} + {2'b00, pp_lh} + {2'b00, joined_row}));
    end

    if (OUT_REG) begin : g_reg
        logic [2*W-1:0] prod_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= z_comb;
        end
        assign prod_o = prod_q;

        a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (prod_o == $past(z_comb)));

        a_r7_reset_zero: assert property (@(posedge clk)
            !rst_n |-> (prod_o == '0));
    end else begin : g_comb
        assign prod_o = z_comb;
    end
endmodule

// File: tb/splitmul_top_tb_top.sv
`timescale 1ns/1ps
module splitmul_top_tb_top;
    localparam int W = 16;
    localparam int H = W / 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   a_in = '0;
    logic [W-1:0]   b_in = '0;
    logic [2*W-1:0] prod_o;

    always #2.5 clk = ~clk;

    splitmul_top #(.W(W), .BLK(4), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .prod_o(prod_o)
    );

    typedef struct {
        logic [W-1:0] x;
        logic [W-1:0] y;
        string        tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic check(input string tag, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                         input string tag);
        item_t it;
        @(negedge clk);
        a_in = x;
        b_in = y;
        it.x = x; it.y = y; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: product register updates at posedge; sample 2 ns later
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && q.size() > 0) begin
                item_t it;
                logic [2*W-1:0] full, ll, hh, midt;
                logic [1:0] ov;
                it   = q.pop_front();
                full = (2*W)'(it.x) * (2*W)'(it.y);
                ll   = (2*W)'(it.x[H-1:0]) * (2*W)'(it.y[H-1:0]);
                hh   = (2*W)'(it.x[W-1:H]) * (2*W)'(it.y[W-1:H]);
                midt = (ll >> H)
                     + (2*W)'(it.x[W-1:H]) * (2*W)'(it.y[H-1:0])
                     + (2*W)'(it.x[H-1:0]) * (2*W)'(it.y[W-1:H])
                     + ((hh & ((2*W)'(1) << H) - 1) << H);
                ov   = 2'(midt >> W);
                check({"R1 ", it.tag}, prod_o, full);
                check({"R2 low quarter ", it.tag},
                      (2*W)'(prod_o[H-1:0]), (2*W)'(ll[H-1:0]));
                check({"R3 top quarter ", it.tag},
                      (2*W)'(prod_o[2*W-1:W+H]),
                      (2*W)'(H'(hh[W-1:H] + (2*W)'(ov))));
                if (it.tag == "R6_ovf2")
                    check("R6 overflow count two", (2*W)'(ov), (2*W)'(2));
            end
        end
    end

    initial begin
        #20000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        a_in = 16'h1234;
        b_in = 16'h5678;
        #7;
        check("R7 reset clears output", prod_o, '0);
        repeat (3) @(posedge clk);
        #1;
        check("R7 reset holds output", prod_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(16'h0000, 16'hBEEF, "R8_zero");
        drive(16'hFFFF, 16'h0000, "R8_zero_b");
        drive(16'hFFFF, 16'hFFFF, "R8_ones");
        drive(16'h0001, 16'h0001, "R8_one");
        for (int i = 0; i < W; i++)
            drive(W'(1) << i, W'(1) << (W - 1 - i), "R8_singlebit");
        drive(16'hF1FF, 16'hF1FF, "R6_ovf2");
        for (int k = 0; k < 256; k++)
            drive({8'(k), 8'hFF}, {8'(k), 8'hFF}, "R6_sweep");
        for (int k = 0; k < 256; k++)
            drive({8'hFF, 8'(k)}, {8'(255 - k), 8'hFF}, "R4_R5_mix");
        for (int i = 0; i < 2000; i++)
            drive(W'($urandom), W'($urandom), "R9_random");

        repeat (3) @(posedge clk);
        #2;
        check("R1 queue drained", (2*W)'(q.size()), '0);

        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R7 async reset mid-run", prod_o, '0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule